// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the SCL clock for an I2C master that drives the line open drain. It either pulls SCL low or lets it go, and it never drives the line high. Each clock phase is timed by a reloadable baud counter. The counter advances once per machine cycle of four system clocks, and it also samples SCL at that rate, taking the line level from a two-flop synchronizer.

When the low phase ends, SCL is released. The counter then stays frozen until the synchronized line reads high. A slave that holds SCL low therefore stretches the clock, and the high phase is timed only from the moment the line really goes high. That high phase always lasts one full counter period. Two one-clock strobes mark the entry into each high phase and each low phase, so that surrounding sequencing logic can align data changes to them.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is asserted, and right after it, SCL is released (`scl_pull_low`=0) and both strobes are 0.
- R2: A low phase holds `scl_pull_low`=1 for exactly 4*max(reload,1) clocks, counted from the clock in which `low_start` is high.
- R3: When the low-phase count expires, the block releases SCL (`scl_pull_low` falls to 0) and does not assert it again until the next low phase starts.
- R4: While SCL is released and the synchronized line is low, the phase counter is frozen and `high_start` is never asserted, however long the stretch lasts.
- R5: After the line is seen high, `high_start` pulses. The next `low_start` follows exactly 4*max(reload,1) clocks later, and `scl_pull_low` stays 0 throughout.
- R6: `high_start` and `low_start` are one-clock pulses that never coincide. `low_start` coincides with the first clock in which `scl_pull_low` is 1.
- R7: A reload value of 0 gives a phase of one machine cycle (4 clocks).
- R8: If `enable` or `run` is 0, on the next clock the block is idle, with SCL released and no strobes. When both return to 1, a low phase starts at the next machine-cycle tick, timed from a freshly loaded count.
- R9: Machine-cycle ticks occur every 4th clock, the first one 3 clocks after reset is released. SCL is judged only at ticks, through a two-flop synchronizer, and all outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| run | input | 1 | Request to generate clock phases |
| reload | input | 7 | Phase length in machine cycles (0 acts as 1) |
| scl_in | input | 1 | Actual SCL line level, asynchronous |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| high_start | output | 1 | One-clock pulse on entry into a high phase |
| low_start | output | 1 | One-clock pulse on entry into a low phase |

## Verification
A wrong phase count or a counter that runs during a stretch changes the clock in which `scl_pull_low` or a strobe toggles. The reference model compares every output on every clock, so such an error shows up within one machine cycle of the phase boundary. A synchronizer or prescaler that is off by one stage shifts `high_start` by one clock after a stretch ends, and the first comparison after the release catches it. A stuck state shows up as a missing strobe within one counter period.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;
endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/scl_phase_core.sv
module scl_phase_core
    import scl_pkg::*;
#(
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          tick,
    input  logic [RW-1:0] reload,
    input  logic          line_high,
    output logic          pull_low,
    output logic          hi_pulse,
    output logic          lo_pulse
);
    typedef struct packed {
        phase_e        ph;
        logic [RW-1:0] cnt;
        logic          pull;
        logic          hs;
        logic          ls;
    } core_t;

    core_t st_d, st_q;
    logic  expire;

    assign expire = (st_q.cnt <= RW'(1));

    always_comb begin
        st_d    = st_q;
        st_d.hs = 1'b0;
        st_d.ls = 1'b0;
        if (!active) begin
            st_d.ph   = PH_IDLE;
            st_d.pull = 1'b0;
            st_d.cnt  = reload;
        end else if (tick) begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph   = PH_LOW;
                    st_d.cnt  = reload;
                    st_d.pull = 1'b1;
                    st_d.ls   = 1'b1;
                end
                PH_LOW: begin
                    if (expire) begin
                        st_d.ph   = PH_WAIT;
                        st_d.pull = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (line_high) begin
                        st_d.ph  = PH_HIGH;
                        st_d.cnt = reload;
                        st_d.hs  = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (expire) begin
                        st_d.ph   = PH_LOW;
                        st_d.cnt  = reload;
                        st_d.pull = 1'b1;
                        st_d.ls   = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.pull <= 1'b0;
            st_q.hs   <= 1'b0;
            st_q.ls   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_low = st_q.pull;
    assign hi_pulse = st_q.hs;
    assign lo_pulse = st_q.ls;
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int RELOAD_W    = 7,
    parameter int MC_DIV      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                run,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                scl_in,
    output logic                scl_pull_low,
    output logic                high_start,
    output logic                low_start
);
    logic mc_tick;
    logic scl_sync;

    scl_tick_gen #(.DIV(MC_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (mc_tick)
    );

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (scl_in),
        .dout (scl_sync)
    );

    scl_phase_core #(.RW(RELOAD_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (enable & run),
        .tick     (mc_tick),
        .reload   (reload),
        .line_high(scl_sync),
        .pull_low (scl_pull_low),
        .hi_pulse (high_start),
        .lo_pulse (low_start)
    );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic run,
    input logic scl_pull_low,
    input logic high_start,
    input logic low_start,
    input logic scl_sync
);
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(high_start && low_start)); // R6

    AST_LOW_WITH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        low_start |-> scl_pull_low); // R6

    AST_PULL_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> low_start); // R3

    AST_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        high_start |-> !scl_pull_low); // R5

    AST_NO_HIGH_IN_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull_low && !scl_sync) |=> !high_start); // R4

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && run) |=> (!scl_pull_low && !high_start && !low_start)); // R8

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!scl_pull_low && !high_start && !low_start); // R1
        end
    end
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .run         (run),
    .scl_pull_low(scl_pull_low),
    .high_start  (high_start),
    .low_start   (low_start),
    .scl_sync    (scl_sync)
);

// File: tb/scl_clkgen_test.sv
`timescale 1ns/1ps
module scl_clkgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       run = 1'b0;
    logic [6:0] reload = 7'd5;
    logic       stretch = 1'b0;
    logic       scl_line;
    logic       scl_pull_low, high_start, low_start;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign scl_line = !scl_pull_low && !stretch;

    scl_clkgen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
        .reload(reload), .scl_in(scl_line),
        .scl_pull_low(scl_pull_low), .high_start(high_start), .low_start(low_start)
    );

    // behavioural reference model
    int m_pre = 0;
    int m_phase = 0;     // 0 idle, 1 low, 2 waiting for line, 3 high
    int m_left = 0;
    bit m_pull = 0, m_hs = 0, m_ls = 0;
    bit sq[$];

    initial begin
        sq.push_back(1'b0);
        sq.push_back(1'b0);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_phase = 0; m_left = 0;
            m_pull = 0; m_hs = 0; m_ls = 0;
            sq.delete(); sq.push_back(1'b0); sq.push_back(1'b0);
        end else begin
            bit line_now, seen, tk;
            int len;
            line_now = !m_pull && !stretch;
            seen = sq[0];
            tk = (m_pre == 3);
            len = (reload == 0) ? 1 : int'(reload);
            m_hs = 0; m_ls = 0;
            if (!(enable && run)) begin
                m_phase = 0; m_pull = 0;
            end else if (tk) begin
                if (m_phase == 0) begin
                    m_phase = 1; m_left = len; m_pull = 1; m_ls = 1;
                end else if (m_phase == 1) begin
                    if (m_left <= 1) begin m_phase = 2; m_pull = 0; end
                    else m_left--;
                end else if (m_phase == 2) begin
                    if (seen) begin m_phase = 3; m_left = len; m_hs = 1; end
                end else begin
                    if (m_left <= 1) begin m_phase = 1; m_left = len; m_pull = 1; m_ls = 1; end
                    else m_left--;
                end
            end
            void'(sq.pop_front());
            sq.push_back(line_now);
            m_pre = (m_pre + 1) % 4;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !finished) begin
            // R9 cycle-exact comparison with the reference model
            check(scl_pull_low == m_pull, "R9 pull", scl_pull_low, m_pull);
            check(high_start == m_hs, "R9 high_start", high_start, m_hs);
            check(low_start == m_ls, "R9 low_start", low_start, m_ls);
        end
        if (cycles >= 100000 && !finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic wait_low_start();
        for (int i = 0; i < 2000 && !low_start; i++) @(negedge clk);
    endtask

    task automatic wait_high_start();
        for (int i = 0; i < 2000 && !high_start; i++) @(negedge clk);
    endtask

    task automatic measure_low(input int n, input string req);
        int cnt = 0;
        int exp = 4 * ((n == 0) ? 1 : n);
        wait_low_start();
        check(scl_pull_low == 1, "R6 low_start with pull", scl_pull_low, 1);
        while (scl_pull_low && cnt < 2000) begin cnt++; @(negedge clk); end
        check(cnt == exp, req, cnt, exp);
    endtask

    task automatic measure_high(input int n, input string req);
        int cnt = 0;
        int exp = 4 * ((n == 0) ? 1 : n);
        bit pulled = 0;
        wait_high_start();
        do begin
            if (scl_pull_low) pulled = 1;
            cnt++; @(negedge clk);
        end while (!low_start && cnt < 2000);
        check(cnt == exp, req, cnt, exp);
        check(pulled == 0, "R5 released in high", pulled, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(!scl_pull_low && !high_start && !low_start, "R1 reset quiet",
              {scl_pull_low, high_start, low_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_pull_low && !high_start && !low_start, "R1 after reset",
              {scl_pull_low, high_start, low_start}, 0);
        enable = 1'b1; run = 1'b1;

        measure_low(5, "R2 low length n=5");
        measure_high(5, "R5 high length n=5");

        reload = 7'd0;
        wait_low_start(); @(negedge clk);
        measure_low(0, "R7 low length n=0");
        measure_high(0, "R7 high length n=0");

        reload = 7'd1;
        wait_low_start(); @(negedge clk);
        measure_low(1, "R2 low length n=1");

        // stretch by a slave
        reload = 7'd3;
        wait_low_start(); @(negedge clk);
        wait_low_start();
        stretch = 1'b1;
        while (scl_pull_low) @(negedge clk);
        begin
            int hs_seen = 0, pulls = 0;
            for (int i = 0; i < 60; i++) begin
                if (high_start) hs_seen++;
                if (scl_pull_low) pulls++;
                @(negedge clk);
            end
            check(hs_seen == 0, "R4 frozen during stretch", hs_seen, 0);
            check(pulls == 0, "R3 stays released", pulls, 0);
        end
        stretch = 1'b0;
        begin
            int lat = 0;
            while (!high_start && lat < 50) begin lat++; @(negedge clk); end
            check(lat >= 3 && lat <= 7, "R9 resume latency", lat, 3);
        end
        measure_high(3, "R5 high after stretch n=3");

        // disable in the middle of a low phase
        wait_low_start(); @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(scl_pull_low == 0, "R8 released on disable", scl_pull_low, 0);
        begin
            int strobes = 0;
            for (int i = 0; i < 20; i++) begin
                if (high_start || low_start || scl_pull_low) strobes++;
                @(negedge clk);
            end
            check(strobes == 0, "R8 idle while disabled", strobes, 0);
        end
        enable = 1'b1;
        measure_low(3, "R8 restart low n=3");

        // run request dropped during high
        wait_high_start(); @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check(!scl_pull_low && !low_start, "R8 idle on run low",
              {scl_pull_low, low_start}, 0);
        repeat (10) @(negedge clk);
        run = 1'b1;
        measure_low(3, "R2 low after run n=3");

        repeat (10) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule